// File: doc/BRIEF.md
# Store Gathering Write Combiner

The combiner sits between a store queue and a 64-bit bus write port. Each cycle it looks at the two oldest pending stores. Each store carries a word address, 32-bit data, four byte enables and three attributes: write-through, cache-inhibited and guarded. When gathering is enabled, two eligible word stores that cover both halves of one 8-byte-aligned doubleword are merged into a single-beat 64-bit write. Every other store goes out alone, and program order is kept.

A store is eligible when all four of its bytes are enabled and its address is word aligned. It must also be write-through or cache-inhibited, and its target must be nonguarded. The combiner only pairs stores that are already both present at the queue head. It never holds an eligible store back to wait for a partner. The two halves may arrive in either address order. Words are placed in their lanes unchanged, with no byte swapping.

A one-entry output register drives the bus request. The combiner tells the queue how many entries to dequeue in the cycle the register loads. While the bus stalls, it dequeues nothing.

Top module: `sg_combiner`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, bus_valid_o is 0 and pop_o is 0.
- R2: With gather_en_i at 0, every store is issued as its own bus request and pop_o never reads 2.
- R3: A store counts as a full aligned word only if its byte enables are 4'b1111 and address bits [1:0] are 00. Any other store is issued alone.
- R4: A store can be gathered only if (write-through or cache-inhibited) and not guarded. A write-back store or a guarded store is issued alone, in queue order.
- R5: Two eligible stores are merged only when address bits [31:3] match and address bit 2 differs. The merged request has address bits [2:0] at 000 and bus_be_o = 8'hFF. The word whose address bit 2 is 0 goes in data bits [31:0]. The other word goes in data bits [63:32].
- R6: The merge of R5 happens whichever of the two words is at the queue head.
- R7: If only one store is pending, it is issued alone at once, even when it is eligible. A later matching store does not merge with it.
- R8: A lone store keeps its address. Its data and byte enables go to the lane chosen by address bit 2 (0: bits [31:0] and enables [3:0]; 1: bits [63:32] and enables [7:4]). The other lane is zero. bus_single_o is 1 with every request.
- R9: While bus_valid_o is 1 and bus_ready_i is 0, the request fields stay stable and pop_o is 0.
- R10: pop_o gives the number of entries dequeued at the coming clock edge: 0, 1, or 2 for a merge. The resulting request shows on bus_valid_o one cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| gather_en_i | input | 1 | Gathering enable |
| hd_valid_i | input | 1 | Oldest queue entry present |
| hd_addr_i | input | ADDR_W | Oldest entry byte address |
| hd_data_i | input | 32 | Oldest entry data |
| hd_be_i | input | 4 | Oldest entry byte enables |
| hd_wt_i | input | 1 | Oldest entry write-through |
| hd_ci_i | input | 1 | Oldest entry cache-inhibited |
| hd_grd_i | input | 1 | Oldest entry guarded |
| nx_valid_i | input | 1 | Second entry present |
| nx_addr_i | input | ADDR_W | Second entry byte address |
| nx_data_i | input | 32 | Second entry data |
| nx_be_i | input | 4 | Second entry byte enables |
| nx_wt_i | input | 1 | Second entry write-through |
| nx_ci_i | input | 1 | Second entry cache-inhibited |
| nx_grd_i | input | 1 | Second entry guarded |
| pop_o | output | 2 | Entries to dequeue this edge |
| bus_valid_o | output | 1 | Bus write request valid |
| bus_ready_i | input | 1 | Bus accepts request |
| bus_addr_o | output | ADDR_W | Request address |
| bus_data_o | output | 64 | Request data |
| bus_be_o | output | 8 | Request byte enables |
| bus_single_o | output | 1 | Single-beat transfer indication |

## Verification
pop_o is a combinational result of the current queue head, the gather enable and the output register state. It is due in the same cycle that the inputs are presented. The bus request it implies appears one clock edge later. A stalled request has to stay unchanged for every cycle that bus_ready_i is low. The bench drives its inputs at the falling edge and compares both pop_o and the bus fields against its model just before the next rising edge. It advances the model's queue and output register only after that edge, so each expected value is compared in exactly the cycle it is due.

// File: rtl/sg_pkg.sv
package sg_pkg;
  // value doubles as the dequeue count
  typedef enum logic [1:0] {
    ISS_NONE = 2'd0,
    ISS_ONE  = 2'd1,
    ISS_PAIR = 2'd2
  } iss_e;
endpackage

// File: rtl/sg_elig.sv
module sg_elig #(
  parameter int WBE = 4,
  localparam int OFF = $clog2(WBE)
) (
  input  logic [OFF-1:0] addr_lo_i,
  input  logic [WBE-1:0] be_i,
  input  logic           wt_i,
  input  logic           ci_i,
  input  logic           grd_i,
  output logic           elig_o
);
  logic full_word;
  logic aligned;
  logic attr_ok;

  assign full_word = &be_i;
  assign aligned   = (addr_lo_i == '0);
  assign attr_ok   = (wt_i | ci_i) & ~grd_i;
  assign elig_o    = full_word & aligned & attr_ok;
endmodule

// File: rtl/sg_pair.sv
module sg_pair
  import sg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WBE    = 4,
  localparam int OFF   = $clog2(WBE)
) (
  input  logic                gather_en_i,
  input  logic                hd_valid_i,
  input  logic                hd_elig_i,
  input  logic [ADDR_W-1:OFF] hd_addr_i,
  input  logic                nx_valid_i,
  input  logic                nx_elig_i,
  input  logic [ADDR_W-1:OFF] nx_addr_i,
  output iss_e                kind_o
);
  logic same_dw;
  logic other_half;
  logic can_pair;

  assign same_dw    = (hd_addr_i[ADDR_W-1:OFF+1] == nx_addr_i[ADDR_W-1:OFF+1]);
  assign other_half = hd_addr_i[OFF] ^ nx_addr_i[OFF];
  assign can_pair   = gather_en_i & hd_elig_i & nx_valid_i & nx_elig_i & same_dw & other_half;

  always_comb begin
    if (!hd_valid_i)   kind_o = ISS_NONE;
    else if (can_pair) kind_o = ISS_PAIR;
    else               kind_o = ISS_ONE;
  end
endmodule

// File: rtl/sg_pack.sv
module sg_pack
  import sg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WBE    = 4,
  localparam int OFF   = $clog2(WBE),
  localparam int WW    = WBE * 8
) (
  input  iss_e              kind_i,
  input  logic [ADDR_W-1:0] hd_addr_i,
  input  logic [WW-1:0]     hd_data_i,
  input  logic [WBE-1:0]    hd_be_i,
  input  logic              nx_sel_i,
  input  logic [WW-1:0]     nx_data_i,
  input  logic [WBE-1:0]    nx_be_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [2*WW-1:0]   data_o,
  output logic [2*WBE-1:0]  be_o
);
  always_comb begin
    addr_o = hd_addr_i;
    data_o = '0;
    be_o   = '0;
    if (hd_addr_i[OFF]) begin
      data_o[2*WW-1:WW]   = hd_data_i;
      be_o[2*WBE-1:WBE]   = hd_be_i;
    end else begin
      data_o[WW-1:0]      = hd_data_i;
      be_o[WBE-1:0]       = hd_be_i;
    end
    if (kind_i == ISS_PAIR) begin
      addr_o = {hd_addr_i[ADDR_W-1:OFF+1], {(OFF+1){1'b0}}};
      if (nx_sel_i) begin
        data_o[2*WW-1:WW] = nx_data_i;
        be_o[2*WBE-1:WBE] = nx_be_i;
      end else begin
        data_o[WW-1:0]    = nx_data_i;
        be_o[WBE-1:0]     = nx_be_i;
      end
    end
  end
endmodule

// File: rtl/sg_out_reg.sv
module sg_out_reg
  import sg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DW     = 64,
  parameter int BEW    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  iss_e              kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     data_i,
  input  logic [BEW-1:0]    be_i,
  output logic              load_o,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DW-1:0]     data_o,
  output logic [BEW-1:0]    be_o,
  output logic              single_o
);
  assign load_o = ~valid_o | ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      addr_o   <= '0;
      data_o   <= '0;
      be_o     <= '0;
      single_o <= 1'b0;
    end else if (load_o) begin
      valid_o  <= (kind_i != ISS_NONE);
      addr_o   <= addr_i;
      data_o   <= data_i;
      be_o     <= be_i;
      single_o <= (kind_i != ISS_NONE);
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(addr_o) && $stable(data_o) && $stable(be_o)) // R9
    else $error("AST_STALL_HOLD");

  AST_LOAD_SHOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o && kind_i != ISS_NONE |=> valid_o && single_o) // R10
    else $error("AST_LOAD_SHOWS");
endmodule

// File: rtl/sg_combiner.sv
module sg_combiner
  import sg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WBE    = 4,
  localparam int OFF   = $clog2(WBE),
  localparam int WW    = WBE * 8,
  localparam int NENT  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gather_en_i,
  input  logic              hd_valid_i,
  input  logic [ADDR_W-1:0] hd_addr_i,
  input  logic [WW-1:0]     hd_data_i,
  input  logic [WBE-1:0]    hd_be_i,
  input  logic              hd_wt_i,
  input  logic              hd_ci_i,
  input  logic              hd_grd_i,
  input  logic              nx_valid_i,
  input  logic [ADDR_W-1:0] nx_addr_i,
  input  logic [WW-1:0]     nx_data_i,
  input  logic [WBE-1:0]    nx_be_i,
  input  logic              nx_wt_i,
  input  logic              nx_ci_i,
  input  logic              nx_grd_i,
  output logic [1:0]        pop_o,
  output logic              bus_valid_o,
  input  logic              bus_ready_i,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [2*WW-1:0]   bus_data_o,
  output logic [2*WBE-1:0]  bus_be_o,
  output logic              bus_single_o
);
  logic [NENT-1:0][ADDR_W-1:0] ent_addr;
  logic [NENT-1:0][WBE-1:0]    ent_be;
  logic [NENT-1:0]             ent_wt, ent_ci, ent_grd, ent_elig;

  assign ent_addr = {nx_addr_i, hd_addr_i};
  assign ent_be   = {nx_be_i, hd_be_i};
  assign ent_wt   = {nx_wt_i, hd_wt_i};
  assign ent_ci   = {nx_ci_i, hd_ci_i};
  assign ent_grd  = {nx_grd_i, hd_grd_i};

  for (genvar g = 0; g < NENT; g++) begin : g_elig
    sg_elig #(.WBE(WBE)) u_elig (
      .addr_lo_i (ent_addr[g][OFF-1:0]),
      .be_i      (ent_be[g]),
      .wt_i      (ent_wt[g]),
      .ci_i      (ent_ci[g]),
      .grd_i     (ent_grd[g]),
      .elig_o    (ent_elig[g])
    );
  end

  iss_e                kind;
  logic [ADDR_W-1:0]   req_addr;
  logic [2*WW-1:0]     req_data;
  logic [2*WBE-1:0]    req_be;
  logic                load;

  sg_pair #(.ADDR_W(ADDR_W), .WBE(WBE)) u_pair (
    .gather_en_i (gather_en_i),
    .hd_valid_i  (hd_valid_i),
    .hd_elig_i   (ent_elig[0]),
    .hd_addr_i   (hd_addr_i[ADDR_W-1:OFF]),
    .nx_valid_i  (nx_valid_i),
    .nx_elig_i   (ent_elig[1]),
    .nx_addr_i   (nx_addr_i[ADDR_W-1:OFF]),
    .kind_o      (kind)
  );

  sg_pack #(.ADDR_W(ADDR_W), .WBE(WBE)) u_pack (
    .kind_i    (kind),
    .hd_addr_i (hd_addr_i),
    .hd_data_i (hd_data_i),
    .hd_be_i   (hd_be_i),
    .nx_sel_i  (nx_addr_i[OFF]),
    .nx_data_i (nx_data_i),
    .nx_be_i   (nx_be_i),
    .addr_o    (req_addr),
    .data_o    (req_data),
    .be_o      (req_be)
  );

  sg_out_reg #(.ADDR_W(ADDR_W), .DW(2*WW), .BEW(2*WBE)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .kind_i   (kind),
    .addr_i   (req_addr),
    .data_i   (req_data),
    .be_i     (req_be),
    .load_o   (load),
    .ready_i  (bus_ready_i),
    .valid_o  (bus_valid_o),
    .addr_o   (bus_addr_o),
    .data_o   (bus_data_o),
    .be_o     (bus_be_o),
    .single_o (bus_single_o)
  );

  assign pop_o = load ? kind : 2'd0;

  AST_NO_POP_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o && !bus_ready_i |-> pop_o == 2'd0) // R9
    else $error("AST_NO_POP_STALL");

  AST_POP_NEEDS_HEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o != 2'd0 |-> hd_valid_i) // R7
    else $error("AST_POP_NEEDS_HEAD");

  AST_PAIR_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o == 2'd2 |-> gather_en_i && nx_valid_i) // R2
    else $error("AST_PAIR_NEEDS_EN");

  AST_PAIR_NONGUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o == 2'd2 |-> !hd_grd_i && !nx_grd_i && (&hd_be_i) && (&nx_be_i)) // R4
    else $error("AST_PAIR_NONGUARD");

  AST_PAIR_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o == 2'd2 |=> bus_valid_o && (&bus_be_o) && bus_addr_o[OFF:0] == '0) // R5
    else $error("AST_PAIR_SHAPE");

  AST_POP_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o != 2'd3) // R10
    else $error("AST_POP_RANGE");
endmodule

// File: tb/sg_combiner_bench.sv
module sg_combiner_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        gather_en_i = 1'b0;
  logic        hd_valid_i, nx_valid_i;
  logic [31:0] hd_addr_i, nx_addr_i, hd_data_i, nx_data_i;
  logic [3:0]  hd_be_i, nx_be_i;
  logic        hd_wt_i, hd_ci_i, hd_grd_i, nx_wt_i, nx_ci_i, nx_grd_i;
  logic [1:0]  pop_o;
  logic        bus_valid_o, bus_ready_i, bus_single_o;
  logic [31:0] bus_addr_o;
  logic [63:0] bus_data_o;
  logic [7:0]  bus_be_o;

  always #4 clk_i = ~clk_i;

  sg_combiner u_sg_combiner (.*);

  // store queue
  logic [31:0] q_addr [256];
  logic [31:0] q_data [256];
  logic [3:0]  q_be   [256];
  logic [2:0]  q_attr [256]; // {grd, ci, wt}
  int wr_ptr = 0, rd_ptr = 0;

  // model of bus register
  logic        m_valid = 1'b0;
  logic [31:0] m_addr;
  logic [63:0] m_data;
  logic [7:0]  m_be;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string tag = "R1";

  task automatic push(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be,
                      input logic wt, input logic ci, input logic grd);
    q_addr[wr_ptr % 256] = a; q_data[wr_ptr % 256] = d; q_be[wr_ptr % 256] = be;
    q_attr[wr_ptr % 256] = {grd, ci, wt};
    wr_ptr++;
  endtask

  function automatic bit elig(input int i);
    return q_be[i % 256] == 4'hF && q_addr[i % 256][1:0] == 2'b00 &&
           (q_attr[i % 256][0] || q_attr[i % 256][1]) && !q_attr[i % 256][2];
  endfunction

  task automatic drive_q();
    hd_valid_i = rd_ptr < wr_ptr;
    nx_valid_i = rd_ptr + 1 < wr_ptr;
    hd_addr_i = q_addr[rd_ptr % 256]; hd_data_i = q_data[rd_ptr % 256];
    hd_be_i = q_be[rd_ptr % 256];
    {hd_grd_i, hd_ci_i, hd_wt_i} = q_attr[rd_ptr % 256];
    nx_addr_i = q_addr[(rd_ptr + 1) % 256]; nx_data_i = q_data[(rd_ptr + 1) % 256];
    nx_be_i = q_be[(rd_ptr + 1) % 256];
    {nx_grd_i, nx_ci_i, nx_wt_i} = q_attr[(rd_ptr + 1) % 256];
  endtask

  task automatic fail(input string r, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_fail++;
    $display("FAIL %s %s actual=%h expected=%h", r, what, act, exp);
  endtask

  // one cycle: drive at negedge, check, step model after posedge
  task automatic step(input logic rdy);
    int   e_pop;
    bit   load;
    logic [31:0] na; logic [63:0] nd; logic [7:0] nb;
    @(negedge clk_i);
    bus_ready_i = rdy;
    drive_q();
    #1;
    load = !m_valid || rdy;
    e_pop = 0;
    if (load && hd_valid_i) begin
      int h = rd_ptr;
      bit pair = gather_en_i && nx_valid_i && elig(h) && elig(h + 1) &&
                 q_addr[h % 256][31:3] == q_addr[(h + 1) % 256][31:3] &&
                 q_addr[h % 256][2] != q_addr[(h + 1) % 256][2];
      e_pop = pair ? 2 : 1;
      nd = 64'd0; nb = 8'd0;
      for (int k = 0; k < e_pop; k++) begin
        int j = (h + k) % 256;
        if (q_addr[j][2]) begin nd[63:32] = q_data[j]; nb[7:4] = q_be[j]; end
        else begin nd[31:0] = q_data[j]; nb[3:0] = q_be[j]; end
      end
      na = pair ? {q_addr[h % 256][31:3], 3'b000} : q_addr[h % 256];
    end
    n_chk++;
    if (pop_o != 2'(e_pop)) fail({tag, "/R10"}, "pop_o", 64'(pop_o), 64'(e_pop));
    n_chk++;
    if (bus_valid_o !== m_valid) fail({tag, "/R10"}, "bus_valid_o", 64'(bus_valid_o), 64'(m_valid));
    else if (m_valid) begin
      n_chk++;
      if (bus_addr_o !== m_addr) fail(tag, "bus_addr_o", 64'(bus_addr_o), 64'(m_addr));
      n_chk++;
      if (bus_data_o !== m_data) fail(tag, "bus_data_o", bus_data_o, m_data);
      n_chk++;
      if (bus_be_o !== m_be) fail(tag, "bus_be_o", 64'(bus_be_o), 64'(m_be));
      n_chk++;
      if (bus_single_o !== 1'b1) fail("R8", "bus_single_o", 64'(bus_single_o), 64'd1);
    end
    @(posedge clk_i);
    #1;
    if (load) begin
      m_valid = (e_pop != 0);
      if (e_pop != 0) begin m_addr = na; m_data = nd; m_be = nb; end
    end
    rd_ptr += e_pop;
  endtask

  task automatic drain();
    for (int i = 0; i < 20; i++) step(1'b1);
  endtask

  initial begin
    bus_ready_i = 1'b0;
    drive_q();
    #20;
    // R1: reset state
    n_chk++;
    if (bus_valid_o !== 1'b0) fail("R1", "bus_valid_o in reset", 64'(bus_valid_o), 64'd0);
    n_chk++;
    if (pop_o !== 2'd0) fail("R1", "pop_o in reset", 64'(pop_o), 64'd0);
    @(negedge clk_i) rst_ni = 1'b1;
    tag = "R1";
    step(1'b1);

    // R2: gather disabled, matched pair goes out as two
    tag = "R2"; gather_en_i = 1'b0;
    push(32'h1000, 32'hA0A0_0001, 4'hF, 1, 0, 0);
    push(32'h1004, 32'hA0A0_0002, 4'hF, 1, 0, 0);
    drain();

    // R5: ascending pair
    tag = "R5"; gather_en_i = 1'b1;
    push(32'h2000, 32'h1111_1111, 4'hF, 1, 0, 0);
    push(32'h2004, 32'h2222_2222, 4'hF, 1, 0, 0);
    drain();
    // R6: descending pair
    tag = "R6";
    push(32'h2014, 32'h3333_3333, 4'hF, 0, 1, 0);
    push(32'h2010, 32'h4444_4444, 4'hF, 0, 1, 0);
    drain();

    // R3: partial enables, misaligned word
    tag = "R3";
    push(32'h3000, 32'h5555_5555, 4'h3, 1, 0, 0);
    push(32'h3004, 32'h6666_6666, 4'hF, 1, 0, 0);
    push(32'h3102, 32'h7777_7777, 4'hF, 1, 0, 0);
    push(32'h3104, 32'h8888_8888, 4'hF, 1, 0, 0);
    drain();

    // R4: write-back, guarded, then in-order single
    tag = "R4";
    push(32'h4000, 32'h9999_0000, 4'hF, 0, 0, 0);
    push(32'h4004, 32'h9999_0001, 4'hF, 0, 0, 0);
    push(32'h4010, 32'h9999_0002, 4'hF, 1, 1, 1);
    push(32'h4014, 32'h9999_0003, 4'hF, 1, 0, 0);
    push(32'h4020, 32'h9999_0004, 4'hF, 0, 1, 0);
    push(32'h4024, 32'h9999_0005, 4'hF, 0, 1, 0);
    drain();

    // R5: different doublewords and same word twice are not merged
    tag = "R5";
    push(32'h5004, 32'hBEEF_0001, 4'hF, 1, 0, 0);
    push(32'h5008, 32'hBEEF_0002, 4'hF, 1, 0, 0);
    push(32'h5008, 32'hBEEF_0003, 4'hF, 1, 0, 0);
    drain();

    // R7: lone eligible store issued at once, partner arrives later
    tag = "R7";
    push(32'h6000, 32'hC0DE_0001, 4'hF, 1, 0, 0);
    step(1'b1); step(1'b1);
    push(32'h6004, 32'hC0DE_0002, 4'hF, 1, 0, 0);
    drain();

    // R8: single store lane placement, upper and lower, partial enables
    tag = "R8";
    push(32'h7004, 32'hD00D_0001, 4'hC, 1, 0, 0);
    push(32'h7101, 32'hD00D_0002, 4'h2, 1, 0, 0);
    drain();

    // R9: stall with mixed ready pattern
    tag = "R9";
    for (int i = 0; i < 6; i++)
      push(32'h8000 + 32'(i * 4), 32'hE000_0000 + 32'(i), 4'hF, 1, 0, (i == 3) ? 1'b1 : 1'b0);
    for (int i = 0; i < 16; i++) step((i % 3) == 2);
    drain();

    // R10: back-to-back pairs under full throughput
    tag = "R10";
    for (int i = 0; i < 8; i++)
      push(32'h9000 + 32'(i * 4), 32'hF000_0000 + 32'(i), 4'hF, 0, 1, 0);
    drain();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule